// File: doc/BRIEF.md
# Nibble-Serial 8x8 Multiplier

This block multiplies two unsigned 8-bit operands and gives a 16-bit product. It has one 4x4 multiplier and uses it for four clock cycles in a row. Each cycle, a 2-bit cycle counter picks one pair of 4-bit operand slices. The 8-bit partial product is then shifted left by 0, 4 or 8 bits and added into a 16-bit accumulator. The product port shows the accumulator directly. It holds the final value, and `done` stays high, until the next start pulse.

A one-cycle `start` pulse begins an operation. The operands must stay stable from the start pulse until `done` rises. A start pulse that arrives while an operation is running drops that operation and begins a new one. A seven-segment output shows the controller step: 0 for idle, 1 for the first accumulate step, 2 for the two middle steps, 3 for the last step, and E for an inconsistent internal state.

Top module: `nibble_mul8`

## Requirements
- R1: After reset, `product` is 0, `done` is 0 and `seg_abcdefg` shows digit 0 (1111110). Bit 6 of `seg_abcdefg` drives segment a and bit 0 drives segment g, and all segments are active high.
- R2: If `start` is high at clock edge E0, then after edge E4 `product` equals `op_a*op_b` and `done` is 1. `done` is 0 after edges E0 to E3.
- R3: The partial products are accumulated in a fixed order. Right after E0, `product` is 0. After E1 it is lo(a)*lo(b). After E2, (lo(a)*hi(b))<<4 has been added. After E3, (hi(a)*lo(b))<<4 has been added. After E4, (hi(a)*hi(b))<<8 has been added. Here lo is bits 3..0 and hi is bits 7..4.
- R4: The display shows the controller step: 1 (0110000) after E0, 2 (1101101) after E1 and E2, 3 (1111001) after E3, and 0 (1111110) after E4.
- R5: After completion, with `start` low, `product`, `done` and the display keep their values even when the operands change.
- R6: A `start` pulse during steps 1 or 2 abandons the running operation. After that edge, `product` is 0, `done` is 0 and the display shows 1. The new operation then completes as in R2.
- R7: A `start` pulse in the same cycle as the final accumulate step wins. After that edge, `product` is 0, `done` is 0 and the display shows 1, and the new operation completes four edges later.
- R8: An active-low reset that arrives during an operation returns the block at once to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins an operation |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Accumulator contents; the final product once done is high |
| done | output | 1 | High from the final accumulate step until the next start |
| seg_abcdefg | output | 7 | Active-high segments a (bit 6) to g (bit 0) showing the controller step |

## Verification
Two events can fall in the same cycle: a new `start` and the final accumulate step, which would otherwise set `done`. The bench forces this by pulsing `start` in the cycle where the display shows 3. It then checks that, after the edge, the accumulator is cleared, `done` stays low and the display shows 1, and that a correct product appears four edges later. A second same-cycle case is a restart in the middle step. It is judged in the same way, and the bench changes the operands so that a leftover partial sum would show up in the result.

// File: rtl/nibble_mul8.sv
module nibble_mul8 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product,
  output logic           done,
  output logic [6:0]     seg_abcdefg
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;

  localparam logic [2:0] S_IDLE = 3'b000;
  localparam logic [2:0] S_LSB  = 3'b001;
  localparam logic [2:0] S_MID  = 3'b010;
  localparam logic [2:0] S_MSB  = 3'b011;
  localparam logic [2:0] S_ERR  = 3'b100;

  logic [2:0]    state, state_nx;
  logic [1:0]    cnt;
  logic [PW-1:0] acc;
  logic          acc_clr_n, acc_ld_n;
  logic [H-1:0]  slice_a, slice_b;
  logic [W-1:0]  part;
  logic [1:0]    shf;
  logic [PW-1:0] placed;
  logic [PW-1:0] sum;

  // cycle counter: free running, zeroed by start
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else            cnt <= cnt + 2'd1;

  // slice selection: 0 lo*lo, 1 lo*hi, 2 hi*lo, 3 hi*hi
  assign slice_a = cnt[1] ? op_a[W-1:H] : op_a[H-1:0];
  assign slice_b = cnt[0] ? op_b[W-1:H] : op_b[H-1:0];
  assign part    = W'(slice_a) * W'(slice_b);

  // shift code: 00 none, 01 by H, 10 by W, 11 none
  assign shf = (cnt == 2'd0) ? 2'b00 : (cnt == 2'd3) ? 2'b10 : 2'b01;

  always_comb
    case (shf)
      2'b01:   placed = PW'(part) << H;
      2'b10:   placed = PW'(part) << W;
      default: placed = PW'(part);
    endcase

  assign sum = acc + placed;

  // controller
  always_comb begin
    state_nx = S_IDLE;
    if (start) state_nx = S_LSB;
    else
      case (state)
        S_IDLE:  state_nx = S_IDLE;
        S_LSB:   state_nx = (cnt == 2'd0) ? S_MID : S_ERR;
        S_MID:   state_nx = (cnt == 2'd1) ? S_MID : (cnt == 2'd2) ? S_MSB : S_ERR;
        S_MSB:   state_nx = (cnt == 2'd3) ? S_IDLE : S_ERR;
        default: state_nx = S_IDLE;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;

  assign acc_clr_n = !start;
  assign acc_ld_n  = !(state == S_LSB || state == S_MID || state == S_MSB);

  // accumulator: clear has priority, load when enable low
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          acc <= '0;
    else if (!acc_clr_n) acc <= '0;
    else if (!acc_ld_n)  acc <= sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     done <= 1'b0;
    else if (start) done <= 1'b0;
    else if (state == S_MSB && cnt == 2'd3) done <= 1'b1;

  assign product = acc;

  // display decoder, segments a..g
  always_comb
    case (state)
      3'b000:  seg_abcdefg = 7'b1111110;
      3'b001:  seg_abcdefg = 7'b0110000;
      3'b010:  seg_abcdefg = 7'b1101101;
      3'b011:  seg_abcdefg = 7'b1111001;
      default: seg_abcdefg = 7'b1001111;
    endcase

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (product == '0 && !done && state == S_LSB));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product)));
  assert_done_after_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == S_MSB && state == S_IDLE));
  assert_msb_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MSB) |-> (cnt == 2'd3));
  assert_idle_display_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> seg_abcdefg == 7'b1111110);
  assert_final_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MSB && start) |=> !done);
endmodule

// File: tb/nibble_mul8_tb_top.sv
module nibble_mul8_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [15:0] product;
  logic        done;
  logic [6:0]  seg_abcdefg;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] D0 = 7'b1111110;
  localparam logic [6:0] D1 = 7'b0110000;
  localparam logic [6:0] D2 = 7'b1101101;
  localparam logic [6:0] D3 = 7'b1111001;

  localparam logic [15:0] VEC [0:7] = '{
    16'h0000, 16'hFFFF, 16'h0FF0, 16'hF00F,
    16'h01FF, 16'h8080, 16'hA53C, 16'h1234
  };

  always #10 clk = ~clk;

  nibble_mul8 dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done), .seg_abcdefg(seg_abcdefg)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [15:0] pp(input logic [7:0] a, input logic [7:0] b, input int k);
    logic [15:0] x;
    case (k)
      0: x = 16'(a[3:0] * b[3:0]);
      1: x = 16'(a[3:0] * b[7:4]) << 4;
      2: x = 16'(a[7:4] * b[3:0]) << 4;
      default: x = 16'(a[7:4] * b[7:4]) << 8;
    endcase
    return x;
  endfunction

  // runs from the start edge through completion, checking every step
  task automatic run_full(input logic [7:0] a, input logic [7:0] b, input string tag);
    logic [15:0] exp;
    op_a = a; op_b = b; start = 1'b1;
    tick;
    start = 1'b0;
    chk({tag, " R3 cleared"}, product, 16'h0);
    chk({tag, " R4 step1"}, 16'(seg_abcdefg), 16'(D1));
    chk({tag, " R2 done low"}, 16'(done), 16'h0);
    exp = 16'h0;
    for (int k = 0; k < 4; k++) begin
      tick;
      exp = exp + pp(a, b, k);
      chk({tag, " R3 partial"}, product, exp);
      chk({tag, " R4 display"}, 16'(seg_abcdefg), (k < 2) ? 16'(D2) : (k == 2) ? 16'(D3) : 16'(D0));
      chk({tag, " R2 done"}, 16'(done), (k == 3) ? 16'h1 : 16'h0);
    end
    chk({tag, " R2 product"}, product, 16'(a) * 16'(b));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #25;
    chk("R1 product", product, 16'h0);
    chk("R1 done", 16'(done), 16'h0);
    chk("R1 display", 16'(seg_abcdefg), 16'(D0));
    rst_n = 1'b1;
    tick;

    for (int i = 0; i < 8; i++)
      run_full(VEC[i][15:8], VEC[i][7:0], "vec");

    // R5: hold after completion while operands change
    op_a = 8'h3C; op_b = 8'hC3;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk("R5 hold product", product, 16'h1234 * 16'h0001 == 0 ? 16'h0 : 16'(8'h12) * 16'(8'h34));
      chk("R5 hold done", 16'(done), 16'h1);
      chk("R5 hold display", 16'(seg_abcdefg), 16'(D0));
    end

    // R6: restart during a middle step with new operands
    op_a = 8'hFF; op_b = 8'hFF; start = 1'b1; tick; start = 1'b0;
    tick; tick;
    op_a = 8'h07; op_b = 8'h90; start = 1'b1; tick; start = 1'b0;
    chk("R6 restart product", product, 16'h0);
    chk("R6 restart done", 16'(done), 16'h0);
    chk("R6 restart display", 16'(seg_abcdefg), 16'(D1));
    for (int i = 0; i < 4; i++) tick;
    chk("R6 new product", product, 16'd7 * 16'h90);
    chk("R6 new done", 16'(done), 16'h1);

    // R7: start in the final accumulate cycle
    op_a = 8'hC8; op_b = 8'h5B; start = 1'b1; tick; start = 1'b0;
    tick; tick; tick;
    chk("R7 at final step display", 16'(seg_abcdefg), 16'(D3));
    start = 1'b1; tick; start = 1'b0;
    chk("R7 product cleared", product, 16'h0);
    chk("R7 done stays low", 16'(done), 16'h0);
    chk("R7 display", 16'(seg_abcdefg), 16'(D1));
    tick; tick; tick;
    chk("R7 not yet done", 16'(done), 16'h0);
    tick;
    chk("R7 product", product, 16'hC8 * 16'h5B);
    chk("R7 done", 16'(done), 16'h1);

    // R8: reset in the middle of an operation
    op_a = 8'h99; op_b = 8'h77; start = 1'b1; tick; start = 1'b0;
    tick; tick;
    #3 rst_n = 1'b0;
    #2;
    chk("R8 product", product, 16'h0);
    chk("R8 done", 16'(done), 16'h0);
    chk("R8 display", 16'(seg_abcdefg), 16'(D0));
    tick;
    rst_n = 1'b1;
    tick;
    run_full(8'h99, 8'h77, "R8 after");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule